// File: doc/BRIEF.md
# Associative Translation Buffer with Probe

This block is a fully associative translation buffer. Each slot holds one dual-page mapping: a per-slot page mask, a virtual page-pair tag, an address-space identifier, a global flag, and two physical frame descriptors. The first descriptor covers the even page and the second covers the odd page. Each descriptor carries a frame number, a 3-bit cache attribute, a dirty flag and a valid flag. The number of slots and all field widths are parameters.

A search request presents a virtual page number and an address-space identifier. One cycle later the block returns a hit flag, the index of the winning slot and the whole stored mapping. The same response serves both as a lookup, which gives the entry, and as a probe, which gives the index. On a miss the index is all ones. Software-style maintenance goes through three more operations. An indexed write installs a mapping. A flush empties the whole table. A replacement pointer exposes the slot it currently names and can be stepped forward to pick the next victim.

Top module: `tlb_assoc`

## Requirements
- R1: A slot matches the request's page number when the two agree on every bit where the slot's stored mask is 0. Bits where the mask is 1 are ignored.
- R2: A slot that matches on page number hits only if its global flag is 1 or its stored identifier equals the request identifier.
- R3: When no slot hits, the response has `rspHit`=0, `rspIndex` all ones and `rspEntry` all zeros.
- R4: A write whose index is ENTRIES or larger leaves every slot unchanged. It raises `wrErr` for exactly the following cycle. A write with an index in range never raises `wrErr`.
- R5: A slot whose even and odd valid flags are both 0 never hits, whatever its tag.
- R6: A flush zeroes every slot and returns the replacement pointer to 0. A flush wins over a write or a pointer step in the same cycle.
- R7: `nxtIdx` shows the replacement pointer and `nxtEntry` shows the contents of that slot. Asserting `nxtAdvance` moves the pointer by one in the next cycle. Without it the pointer holds.
- R8: An in-range write stores `wrEntry` into slot `wrIndex`, visible from the next cycle. The entry is packed, from MSB to LSB, as mask[VPN_W], tag[VPN_W], identifier[ASID_W], global[1], even descriptor, odd descriptor. Each descriptor is packed, from MSB to LSB, as frame[PFN_W], attribute[3], dirty[1], valid[1].
- R9: When several slots hit, the one with the lowest index is reported.
- R10: Stepping the pointer past slot ENTRIES-1 wraps it to 0.
- R11: The response to a request appears on the clock edge after the request, with `rspValid` high for that one cycle only. A search sees the table as it was before any write or flush in the same cycle. Response data holds while no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Search request strobe |
| reqVpn | input | VPN_W | Page number to search for |
| reqAsid | input | ASID_W | Address-space identifier of the request |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspHit | output | 1 | A slot matched |
| rspIndex | output | IDX_W+1 | Winning slot, all ones on miss |
| rspEntry | output | ENTRY_W | Stored mapping of the winning slot, zero on miss |
| wrEn | input | 1 | Indexed write strobe |
| wrIndex | input | IDX_W+1 | Slot to write; ENTRIES and above is out of range |
| wrEntry | input | ENTRY_W | Mapping to install |
| wrErr | output | 1 | Out-of-range write seen in the previous cycle |
| flushEn | input | 1 | Clear the table and the pointer |
| nxtAdvance | input | 1 | Step the replacement pointer |
| nxtIdx | output | IDX_W | Current replacement pointer |
| nxtEntry | output | ENTRY_W | Contents of the slot at the pointer |

## Verification
Two states are hard to reach from the ports. One is several slots hitting at once, where the lowest index has to win. The other is a slot that looks like a hit but must be rejected because of its identifier, its valid flags or its mask. The stimulus installs overlapping tags on purpose: the same tag in a low and a high slot, masked tags that cover a neighbour's page number, and global and non-global twins. It then searches in the same cycle as a write or flush to the slot in question. A long run of random traffic follows. It draws from a small pool of tags, masks and identifiers, so collisions and masked aliases occur often, and it is compared every cycle against a behavioural model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Per-cycle control strobes sent from the control unit to the datapath.
  typedef struct packed {
    logic searchGo;   // capture a search response this cycle
    logic writeSlot;  // install wrEntry into the selected slot
    logic clearAll;   // zero the whole table
  } tlbStrobes_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int VPN_W   = 19,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20,
  localparam int DESC_W  = PFN_W + 5,
  localparam int ENTRY_W = 2 * VPN_W + ASID_W + 1 + 2 * DESC_W
) (
  input  logic [ENTRY_W-1:0] slotEntry,
  input  logic [VPN_W-1:0]   reqVpn,
  input  logic [ASID_W-1:0]  reqAsid,
  output logic               slotHit
);
  localparam int MASK_LSB = ENTRY_W - VPN_W;
  localparam int TAG_LSB  = MASK_LSB - VPN_W;
  localparam int ASID_LSB = TAG_LSB - ASID_W;
  localparam int GLB_BIT  = 2 * DESC_W;
  localparam int EVV_BIT  = DESC_W;
  localparam int ODV_BIT  = 0;

  logic [VPN_W-1:0]  slotMask;
  logic [VPN_W-1:0]  slotTag;
  logic [ASID_W-1:0] slotAsid;
  logic              tagOk;
  logic              asidOk;
  logic              present;

  always_comb begin
    slotMask = slotEntry[MASK_LSB +: VPN_W];
    slotTag  = slotEntry[TAG_LSB +: VPN_W];
    slotAsid = slotEntry[ASID_LSB +: ASID_W];
    tagOk    = ((slotTag ^ reqVpn) & ~slotMask) == '0;
    asidOk   = slotEntry[GLB_BIT] || (slotAsid == reqAsid);
    present  = slotEntry[EVV_BIT] || slotEntry[ODV_BIT];
    slotHit  = tagOk && asidOk && present;
  end
endmodule

// File: rtl/tlb_ctl.sv
module tlb_ctl
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             wrEn,
  input  logic [IDX_W:0]   wrIndex,
  input  logic             flushEn,
  input  logic             nxtAdvance,
  output tlbStrobes_t      strobes,
  output logic [IDX_W-1:0] wrSlot,
  output logic             wrErr,
  output logic [IDX_W-1:0] nxtIdx
);
  localparam logic [IDX_W:0]   LIMIT = (IDX_W + 1)'(ENTRIES);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(ENTRIES - 1);

  logic             inRange;
  logic             stepPtr;
  logic [IDX_W-1:0] ptrQ;
  logic [IDX_W-1:0] ptrNext;
  logic             errQ;

  always_comb begin
    inRange            = wrIndex < LIMIT;
    strobes.searchGo   = reqValid;
    strobes.clearAll   = flushEn;
    strobes.writeSlot  = wrEn && inRange && !flushEn;
    wrSlot             = wrIndex[IDX_W-1:0];
    stepPtr            = nxtAdvance && !flushEn;
  end

  always_comb begin
    ptrNext = ptrQ;
    if (flushEn)
      ptrNext = '0;
    else if (stepPtr)
      ptrNext = (ptrQ == LAST) ? '0 : ptrQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
      errQ <= 1'b0;
    end else begin
      ptrQ <= ptrNext;
      errQ <= wrEn && !inRange;
    end
  end

  assign nxtIdx = ptrQ;
  assign wrErr  = errQ;
endmodule

// File: rtl/tlb_dp.sv
module tlb_dp
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 19,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int DESC_W  = PFN_W + 5,
  localparam int ENTRY_W = 2 * VPN_W + ASID_W + 1 + 2 * DESC_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlbStrobes_t        strobes,
  input  logic [IDX_W-1:0]   wrSlot,
  input  logic [ENTRY_W-1:0] wrEntry,
  input  logic [VPN_W-1:0]   reqVpn,
  input  logic [ASID_W-1:0]  reqAsid,
  input  logic [IDX_W-1:0]   nxtIdx,
  output logic               rspValid,
  output logic               rspHit,
  output logic [IDX_W:0]     rspIndex,
  output logic [ENTRY_W-1:0] rspEntry,
  output logic [ENTRY_W-1:0] nxtEntry
);
  logic [ENTRY_W-1:0] slotQ   [ENTRIES];
  logic [ENTRIES-1:0] hitVec;
  logic               anyHit;
  logic [IDX_W-1:0]   winIdx;
  logic [ENTRY_W-1:0] winEntry;

  // One storage slot and one comparator per table position.
  for (genvar s = 0; s < ENTRIES; s++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        slotQ[s] <= '0;
      else if (strobes.clearAll)
        slotQ[s] <= '0;
      else if (strobes.writeSlot && (wrSlot == IDX_W'(s)))
        slotQ[s] <= wrEntry;
    end

    tlb_match #(
      .VPN_W (VPN_W),
      .ASID_W(ASID_W),
      .PFN_W (PFN_W)
    ) match_i (
      .slotEntry(slotQ[s]),
      .reqVpn   (reqVpn),
      .reqAsid  (reqAsid),
      .slotHit  (hitVec[s])
    );
  end

  // Lowest index wins: scan from the top so the lowest hit is written last.
  always_comb begin
    anyHit = |hitVec;
    winIdx = '0;
    for (int s = ENTRIES - 1; s >= 0; s--) begin
      if (hitVec[s])
        winIdx = IDX_W'(s);
    end
    winEntry = anyHit ? slotQ[winIdx] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspIndex <= '1;
      rspEntry <= '0;
    end else begin
      rspValid <= strobes.searchGo;
      if (strobes.searchGo) begin
        rspHit   <= anyHit;
        rspIndex <= anyHit ? {1'b0, winIdx} : '1;
        rspEntry <= winEntry;
      end
    end
  end

  assign nxtEntry = slotQ[nxtIdx];
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 19,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int DESC_W  = PFN_W + 5,
  localparam int ENTRY_W = 2 * VPN_W + ASID_W + 1 + 2 * DESC_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [VPN_W-1:0]   reqVpn,
  input  logic [ASID_W-1:0]  reqAsid,
  output logic               rspValid,
  output logic               rspHit,
  output logic [IDX_W:0]     rspIndex,
  output logic [ENTRY_W-1:0] rspEntry,
  input  logic               wrEn,
  input  logic [IDX_W:0]     wrIndex,
  input  logic [ENTRY_W-1:0] wrEntry,
  output logic               wrErr,
  input  logic               flushEn,
  input  logic               nxtAdvance,
  output logic [IDX_W-1:0]   nxtIdx,
  output logic [ENTRY_W-1:0] nxtEntry
);
  tlbStrobes_t      strobes;
  logic [IDX_W-1:0] wrSlot;

  tlb_ctl #(.ENTRIES(ENTRIES)) ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .wrEn      (wrEn),
    .wrIndex   (wrIndex),
    .flushEn   (flushEn),
    .nxtAdvance(nxtAdvance),
    .strobes   (strobes),
    .wrSlot    (wrSlot),
    .wrErr     (wrErr),
    .nxtIdx    (nxtIdx)
  );

  tlb_dp #(
    .ENTRIES(ENTRIES),
    .VPN_W  (VPN_W),
    .ASID_W (ASID_W),
    .PFN_W  (PFN_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrSlot  (wrSlot),
    .wrEntry (wrEntry),
    .reqVpn  (reqVpn),
    .reqAsid (reqAsid),
    .nxtIdx  (nxtIdx),
    .rspValid(rspValid),
    .rspHit  (rspHit),
    .rspIndex(rspIndex),
    .rspEntry(rspEntry),
    .nxtEntry(nxtEntry)
  );
endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 19,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int DESC_W  = PFN_W + 5,
  localparam int ENTRY_W = 2 * VPN_W + ASID_W + 1 + 2 * DESC_W
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [VPN_W-1:0]   reqVpn,
  input logic [ASID_W-1:0]  reqAsid,
  input logic               rspValid,
  input logic               rspHit,
  input logic [IDX_W:0]     rspIndex,
  input logic [ENTRY_W-1:0] rspEntry,
  input logic               wrEn,
  input logic [IDX_W:0]     wrIndex,
  input logic               wrErr,
  input logic               flushEn,
  input logic               nxtAdvance,
  input logic [IDX_W-1:0]   nxtIdx,
  input logic [ENTRY_W-1:0] nxtEntry
);
  localparam int MASK_LSB = ENTRY_W - VPN_W;
  localparam int TAG_LSB  = MASK_LSB - VPN_W;
  localparam int ASID_LSB = TAG_LSB - ASID_W;
  localparam logic [IDX_W:0]   LIMIT = (IDX_W + 1)'(ENTRIES);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(ENTRIES - 1);

  AST_HIT_TAG_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit) |->
      (((rspEntry[TAG_LSB +: VPN_W] ^ $past(reqVpn)) & ~rspEntry[MASK_LSB +: VPN_W]) == '0)); // R1

  AST_HIT_ASID_OK: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit) |->
      (rspEntry[2*DESC_W] || (rspEntry[ASID_LSB +: ASID_W] == $past(reqAsid)))); // R2

  AST_MISS_ENCODING: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> ((&rspIndex) && (rspEntry == '0))); // R3

  AST_BAD_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrIndex >= LIMIT)) |=> wrErr); // R4

  AST_GOOD_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && (wrIndex >= LIMIT)) |=> !wrErr); // R4

  AST_HIT_PRESENT: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit) |-> (rspEntry[DESC_W] || rspEntry[0])); // R5

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    flushEn |=> ((nxtIdx == '0) && (nxtEntry == '0))); // R6

  AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!flushEn && !nxtAdvance) |=> $stable(nxtIdx)); // R7

  AST_HIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit) |-> (rspIndex < LIMIT)); // R9

  AST_PTR_WRAPS: assert property (@(posedge clk) disable iff (!rstN)
    (!flushEn && nxtAdvance && (nxtIdx == LAST)) |=> (nxtIdx == '0)); // R10

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R11

  AST_RSP_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R11
endmodule

bind tlb_assoc tlb_assoc_chk #(
  .ENTRIES(ENTRIES),
  .VPN_W  (VPN_W),
  .ASID_W (ASID_W),
  .PFN_W  (PFN_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqVpn    (reqVpn),
  .reqAsid   (reqAsid),
  .rspValid  (rspValid),
  .rspHit    (rspHit),
  .rspIndex  (rspIndex),
  .rspEntry  (rspEntry),
  .wrEn      (wrEn),
  .wrIndex   (wrIndex),
  .wrErr     (wrErr),
  .flushEn   (flushEn),
  .nxtAdvance(nxtAdvance),
  .nxtIdx    (nxtIdx),
  .nxtEntry  (nxtEntry)
);

// File: tb/tlb_assoc_tb_top.sv
module tlb_assoc_tb_top;
  localparam int ENTRIES = 8;
  localparam int VPN_W   = 19;
  localparam int ASID_W  = 8;
  localparam int PFN_W   = 20;
  localparam int IDX_W   = 3;
  localparam int DESC_W  = PFN_W + 5;
  localparam int ENTRY_W = 2 * VPN_W + ASID_W + 1 + 2 * DESC_W;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               reqValid = 1'b0;
  logic [VPN_W-1:0]   reqVpn = '0;
  logic [ASID_W-1:0]  reqAsid = '0;
  logic               rspValid;
  logic               rspHit;
  logic [IDX_W:0]     rspIndex;
  logic [ENTRY_W-1:0] rspEntry;
  logic               wrEn = 1'b0;
  logic [IDX_W:0]     wrIndex = '0;
  logic [ENTRY_W-1:0] wrEntry = '0;
  logic               wrErr;
  logic               flushEn = 1'b0;
  logic               nxtAdvance = 1'b0;
  logic [IDX_W-1:0]   nxtIdx;
  logic [ENTRY_W-1:0] nxtEntry;

  always #2.5 clk = ~clk;

  tlb_assoc #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)
  ) dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqVpn(reqVpn), .reqAsid(reqAsid),
    .rspValid(rspValid), .rspHit(rspHit), .rspIndex(rspIndex), .rspEntry(rspEntry),
    .wrEn(wrEn), .wrIndex(wrIndex), .wrEntry(wrEntry), .wrErr(wrErr),
    .flushEn(flushEn), .nxtAdvance(nxtAdvance),
    .nxtIdx(nxtIdx), .nxtEntry(nxtEntry)
  );

  // Behavioural reference state
  logic [ENTRY_W-1:0] refTable [ENTRIES];
  int                 refPtr;
  logic               expRspValid;
  logic               expRspHit;
  logic [IDX_W:0]     expRspIndex;
  logic [ENTRY_W-1:0] expRspEntry;
  logic               expWrErr;

  int    checks = 0;
  int    errors = 0;
  string curTag = "R6";
  bit    finished = 0;

  task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [ENTRY_W-1:0] mkEntry(
      logic [VPN_W-1:0] mask, logic [VPN_W-1:0] tag, logic [ASID_W-1:0] asid, logic glb,
      logic [PFN_W-1:0] pfnE, logic [2:0] attrE, logic dE, logic vE,
      logic [PFN_W-1:0] pfnO, logic [2:0] attrO, logic dO, logic vO);
    return {mask, tag, asid, glb, pfnE, attrE, dE, vE, pfnO, attrO, dO, vO};
  endfunction

  // Reference search: first slot, counting upward, that satisfies the rules.
  function automatic int refSearch(logic [VPN_W-1:0] vpn, logic [ASID_W-1:0] asid);
    for (int i = 0; i < ENTRIES; i++) begin
      logic [ENTRY_W-1:0] e;
      logic [VPN_W-1:0] m, t;
      logic [ASID_W-1:0] a;
      bit g, present;
      e = refTable[i];
      m = e[ENTRY_W-1 -: VPN_W];
      t = e[ENTRY_W-1-VPN_W -: VPN_W];
      a = e[ENTRY_W-1-2*VPN_W -: ASID_W];
      g = e[2*DESC_W];
      present = e[DESC_W] | e[0];
      if (present && ((vpn & ~m) == (t & ~m)) && (g || a == asid))
        return i;
    end
    return -1;
  endfunction

  task automatic clearIns();
    reqValid = 0; wrEn = 0; flushEn = 0; nxtAdvance = 0;
  endtask

  // Called at a falling edge with inputs set: predict, advance one clock, compare.
  task automatic step();
    int hitAt;
    expRspValid = reqValid;
    if (reqValid) begin
      hitAt = refSearch(reqVpn, reqAsid);
      expRspHit   = (hitAt >= 0);
      expRspIndex = (hitAt >= 0) ? (IDX_W+1)'(hitAt) : '1;
      expRspEntry = (hitAt >= 0) ? refTable[hitAt] : '0;
    end
    expWrErr = wrEn && (wrIndex >= ENTRIES);
    if (flushEn) begin
      for (int i = 0; i < ENTRIES; i++) refTable[i] = '0;
      refPtr = 0;
    end else begin
      if (wrEn && wrIndex < ENTRIES) refTable[wrIndex] = wrEntry;
      if (nxtAdvance) refPtr = (refPtr + 1) % ENTRIES;
    end
    @(negedge clk);
    chk(curTag, "rspValid", 128'(rspValid), 128'(expRspValid));
    chk(curTag, "rspHit",   128'(rspHit),   128'(expRspHit));
    chk(curTag, "rspIndex", 128'(rspIndex), 128'(expRspIndex));
    chk(curTag, "rspEntry", 128'(rspEntry), 128'(expRspEntry));
    chk(curTag, "wrErr",    128'(wrErr),    128'(expWrErr));
    chk(curTag, "nxtIdx",   128'(nxtIdx),   128'(refPtr));
    chk(curTag, "nxtEntry", 128'(nxtEntry), 128'(refTable[refPtr]));
  endtask

  task automatic doWrite(int idx, logic [ENTRY_W-1:0] e);
    clearIns(); wrEn = 1; wrIndex = (IDX_W+1)'(idx); wrEntry = e; step();
  endtask

  task automatic doSearch(logic [VPN_W-1:0] vpn, logic [ASID_W-1:0] asid);
    clearIns(); reqValid = 1; reqVpn = vpn; reqAsid = asid; step();
  endtask

  task automatic doAdvance();
    clearIns(); nxtAdvance = 1; step();
  endtask

  task automatic doIdle();
    clearIns(); step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) refTable[i] = '0;
    refPtr = 0;
    expRspValid = 0; expRspHit = 0; expRspIndex = '1; expRspEntry = '0; expWrErr = 0;
    repeat (3) @(negedge clk);
    // Reset state (R6): empty table, pointer at zero, no response
    chk("R6", "reset nxtIdx", 128'(nxtIdx), 0);
    chk("R6", "reset nxtEntry", 128'(nxtEntry), 0);
    chk("R11", "reset rspValid", 128'(rspValid), 0);
    chk("R4", "reset wrErr", 128'(wrErr), 0);
    rstN = 1;
    @(negedge clk);

    // R8 install distinct mappings, then R7 walk the pointer over them
    curTag = "R8";
    for (int i = 0; i < ENTRIES; i++)
      doWrite(i, mkEntry('0, VPN_W'(i*16), 8'd1, 1'b0, PFN_W'(100+i), 3'(i), 1'b1, 1'b1,
                         PFN_W'(200+i), 3'(7-i), 1'b0, 1'b1));
    curTag = "R7";
    for (int i = 0; i < ENTRIES; i++) begin doAdvance(); doIdle(); end

    // R1 masked tag bits
    curTag = "R1";
    doWrite(2, mkEntry(19'h3, 19'h100, 8'd1, 1'b0, 20'hABC, 3'd2, 1'b1, 1'b1, 20'hDEF, 3'd3, 1'b1, 1'b1));
    doSearch(19'h103, 8'd1);
    doSearch(19'h101, 8'd1);
    doSearch(19'h104, 8'd1);

    // R2 identifier and global flag
    curTag = "R2";
    doWrite(3, mkEntry('0, 19'h200, 8'd5, 1'b0, 20'h1, 3'd0, 1'b0, 1'b1, 20'h2, 3'd0, 1'b0, 1'b1));
    doWrite(4, mkEntry('0, 19'h300, 8'd5, 1'b1, 20'h3, 3'd1, 1'b1, 1'b0, 20'h4, 3'd1, 1'b1, 1'b1));
    doSearch(19'h200, 8'd5);
    doSearch(19'h200, 8'd6);
    doSearch(19'h300, 8'd9);

    // R5 presence needs a valid flag
    curTag = "R5";
    doWrite(5, mkEntry('0, 19'h400, 8'd1, 1'b1, 20'h5, 3'd0, 1'b1, 1'b0, 20'h6, 3'd0, 1'b1, 1'b0));
    doSearch(19'h400, 8'd1);
    doWrite(5, mkEntry('0, 19'h400, 8'd1, 1'b1, 20'h5, 3'd0, 1'b1, 1'b0, 20'h6, 3'd0, 1'b1, 1'b1));
    doSearch(19'h400, 8'd1);

    // R9 duplicate hits, lowest index reported
    curTag = "R9";
    doWrite(6, mkEntry('0, 19'h500, 8'd2, 1'b0, 20'h66, 3'd0, 1'b1, 1'b1, 20'h67, 3'd0, 1'b1, 1'b1));
    doWrite(1, mkEntry(19'hF, 19'h500, 8'd2, 1'b0, 20'h11, 3'd0, 1'b1, 1'b1, 20'h12, 3'd0, 1'b1, 1'b1));
    doSearch(19'h500, 8'd2);

    // R11 search in the same cycle as a write sees the old contents
    curTag = "R11";
    clearIns(); reqValid = 1; reqVpn = 19'h500; reqAsid = 8'd2;
    wrEn = 1; wrIndex = 4'd1; wrEntry = '0; step();
    doSearch(19'h500, 8'd2);
    doIdle();

    // R3 miss encoding
    curTag = "R3";
    doSearch(19'h7FFFF, 8'd1);
    doSearch(19'h200, 8'd7);

    // R4 out-of-range writes are dropped and flagged
    curTag = "R4";
    doWrite(8, mkEntry('0, 19'h600, 8'd1, 1'b1, 20'h9, 3'd0, 1'b1, 1'b1, 20'h9, 3'd0, 1'b1, 1'b1));
    doWrite(15, mkEntry('1, 19'h600, 8'd1, 1'b1, 20'h9, 3'd0, 1'b1, 1'b1, 20'h9, 3'd0, 1'b1, 1'b1));
    doSearch(19'h600, 8'd1);
    doIdle();

    // R10 wrap of the pointer
    curTag = "R10";
    for (int i = 0; i < 2*ENTRIES + 3; i++) doAdvance();

    // R6 flush beats write and step in the same cycle
    curTag = "R6";
    clearIns(); flushEn = 1; nxtAdvance = 1; wrEn = 1; wrIndex = 4'd0;
    wrEntry = mkEntry('0, 19'h700, 8'd1, 1'b1, 20'h1, 3'd0, 1'b1, 1'b1, 20'h1, 3'd0, 1'b1, 1'b1);
    step();
    doSearch(19'h700, 8'd1);
    doSearch(19'h300, 8'd5);

    // R11 mixed random traffic with a small pool of tags and identifiers
    curTag = "R11";
    for (int n = 0; n < 4000; n++) begin
      int m;
      clearIns();
      reqValid   = ($urandom_range(0, 1) == 1);
      reqVpn     = VPN_W'($urandom_range(0, 15));
      reqAsid    = ASID_W'($urandom_range(0, 3));
      wrEn       = ($urandom_range(0, 2) == 0);
      wrIndex    = (IDX_W+1)'($urandom_range(0, 10));
      m          = $urandom_range(0, 3);
      wrEntry    = mkEntry(VPN_W'((1 << m) - 1), VPN_W'($urandom_range(0, 15)),
                           ASID_W'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                           PFN_W'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
                           PFN_W'($urandom), 3'($urandom), 1'($urandom), 1'($urandom));
      flushEn    = ($urandom_range(0, 60) == 0);
      nxtAdvance = ($urandom_range(0, 3) == 0);
      step();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule